// File: doc/BRIEF.md
# Reset Supervisor with Cause Register and Watchdog

This block turns several reset requests into one system reset and keeps a record of which request caused it. The requests are a PLL lock loss, a power-good failure, the external reset pin and an internal watchdog timeout. Any active request asserts `sys_rst` at once. The reset stays asserted for a fixed number of clock cycles after the last request goes away.

Only `por_n` clears the cause bits. A system reset therefore leaves them in place, and software can read them after it restarts. Each cause bit is set when its source is active. Reading the status register returns the bits and then clears them. The watchdog counts clock cycles while it is enabled, and a service strobe restarts the count. If it reaches its limit, it requests a system reset.

Software can switch the watchdog off through a configuration bit. Every system reset switches it back on. Both registers show a fixed revision code in their top four bits. All inputs are taken as synchronous to `clk`.

Top module: `sysrst_guard`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1. After power-on, both the configuration register (`bus_addr`=0) and the status register (`bus_addr`=1) read 0x3000.
- R2: After the last clock edge at which any reset source is sampled active, `sys_rst` stays 1 for exactly HOLD_CYCLES more clock cycles and then falls.
- R3: A PLL lock loss (`pll_unlock`=1) asserts `sys_rst` and sets status bit 8.
- R4: A power-good failure (`pwr_fail`=1) asserts `sys_rst` and sets status bit 10.
- R5: A low `ext_rst_n` asserts `sys_rst` and sets status bit 11 only while `std_mode`=1. While `std_mode`=0 the pin has no effect on `sys_rst` or on the status register.
- R6: With the watchdog enabled and no service strobe, `sys_rst` rises at the (WD_LIMIT+1)-th clock edge after the edge at which it fell. This also sets status bit 9.
- R7: A `wd_kick` pulse restarts the watchdog count. Kicks spaced no more than WD_LIMIT cycles apart keep `sys_rst` low.
- R8: Writing 1 to configuration bit 9 disables the watchdog. The other written bits are ignored, and configuration reads show only bit 9 below the revision code.
- R9: Any system reset clears configuration bit 9 to 0, which re-enables the watchdog. Writes to the configuration register are ignored while `sys_rst` is 1.
- R10: Status bits accumulate and persist through system resets. A read returns the current bits and clears them at that clock edge. A source that is active in the same cycle as the read wins, so its bit stays set.
- R11: Bits 15:12 of every read are 0011. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pll_unlock | input | 1 | PLL lock lost (1 = failure) |
| pwr_fail | input | 1 | Power-good failure (1 = failure) |
| ext_rst_n | input | 1 | External reset pin, active low |
| std_mode | input | 1 | 1 = standard interface mode, which enables the external pin |
| wd_kick | input | 1 | Watchdog service strobe |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = configuration, 1 = status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (0 when `bus_sel`=0) |
| sys_rst | output | 1 | System reset, active high |

## Verification
The hardest case to reach is the exact watchdog timeout. It needs the counter to start from zero at a known edge, with no kick and the watchdog enabled. The stimulus gets there by stopping the background kicker and forcing a short PLL reset. It then counts the hold cycles and the low cycles in one pass from that same edge. A second hard case is a status read that lands on the same edge as a new reset source. The bench raises `pll_unlock` in the cycle of the read to check that the new bit survives the clear.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam logic [3:0] REV_CODE = 4'b0011;

  typedef enum logic { REG_CFG = 1'b0, REG_STAT = 1'b1 } reg_sel_e;

  // Cause vector index order equals status bit order (bit 8 + index)
  localparam int CAUSE_PLL  = 0;
  localparam int CAUSE_WDOG = 1;
  localparam int CAUSE_PWR  = 2;
  localparam int CAUSE_EXT  = 3;
  localparam int NCAUSE     = 4;

  localparam int WD_OFF_BIT = 9;

  function automatic logic [15:0] pack_status(logic [NCAUSE-1:0] c);
    return {REV_CODE, c, 8'h00};
  endfunction

  function automatic logic [15:0] pack_cfg(logic off);
    return {REV_CODE, 2'b00, off, 9'h000};
  endfunction
endpackage

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic src_any,
  output logic sys_rst
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_CYCLES);

  logic [CW-1:0] hold_q;

  function automatic logic [CW-1:0] hold_next(logic [CW-1:0] c, logic s);
    if (s)            return HOLD;
    else if (c != '0) return c - 1'b1;
    else              return '0;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) hold_q <= HOLD;
    else        hold_q <= hold_next(hold_q, src_any);
  end

  assign sys_rst = (hold_q != '0);

  // R2: any sampled source leaves reset asserted on the next cycle
  a_r2_src_asserts: assert property (@(posedge clk) disable iff (!por_n)
    src_any |=> sys_rst);
  // R2: reset only releases after a cycle with no source
  a_r2_fall_quiet: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> $past(!src_any));
endmodule

// File: rtl/sysrst_wdog.sv
module sysrst_wdog #(
  parameter int WD_LIMIT = 40
) (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst,
  input  logic wd_en,
  input  logic kick,
  output logic wd_fire
);
  localparam int CW = $clog2(WD_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(WD_LIMIT);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] wd_next(logic [CW-1:0] c, logic r, logic en, logic k);
    if (r || !en || k) return '0;
    else if (c != LIM) return c + 1'b1;
    else               return c;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= wd_next(cnt_q, sys_rst, wd_en, kick);
  end

  assign wd_fire = (cnt_q == LIM);

  // R7: a kick outside reset leaves no timeout on the next cycle
  a_r7_kick_clears: assert property (@(posedge clk) disable iff (!por_n)
    (kick && !sys_rst) |=> !wd_fire);
  // R8: a watchdog disabled for two cycles never fires
  a_r8_off_silent: assert property (@(posedge clk) disable iff (!por_n)
    (!wd_en && $past(!wd_en)) |-> !wd_fire);
endmodule

// File: rtl/sysrst_regs.sv
module sysrst_regs
  import sysrst_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst,
  input  logic [NCAUSE-1:0]  cause_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  output logic               wd_en
);
  logic [NCAUSE-1:0] status_q;
  logic              wd_off_q;
  logic              rd_stat;
  logic              wr_cfg;
  logic              unused_wdata;

  assign rd_stat = bus_sel && !bus_wr && (reg_sel_e'(bus_addr) == REG_STAT);
  assign wr_cfg  = bus_sel &&  bus_wr && (reg_sel_e'(bus_addr) == REG_CFG);
  assign unused_wdata = ^{bus_wdata[15:WD_OFF_BIT+1], bus_wdata[WD_OFF_BIT-1:0]};

  // Cause bits live only in the power-on domain
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) status_q <= '0;
    else        status_q <= cause_in | (rd_stat ? '0 : status_q);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      wd_off_q <= 1'b0;
    else if (sys_rst) wd_off_q <= 1'b0;
    else if (wr_cfg)  wd_off_q <= bus_wdata[WD_OFF_BIT];
  end

  always_comb begin
    if (!bus_sel)                              bus_rdata = '0;
    else if (reg_sel_e'(bus_addr) == REG_STAT) bus_rdata = pack_status(status_q);
    else                                       bus_rdata = pack_cfg(wd_off_q);
  end

  assign wd_en = !wd_off_q;

  // R10: without a read no captured bit is lost
  a_r10_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !$past(rd_stat) |-> ((status_q & $past(status_q)) == $past(status_q)));
  // R10: an active source is recorded on the next cycle, read or not
  a_r10_capture: assert property (@(posedge clk) disable iff (!por_n)
    (cause_in != '0) |=> ((status_q & $past(cause_in)) == $past(cause_in)));
  // R9: a system reset re-enables the watchdog
  a_r9_cfg_clr: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> !wd_off_q);
endmodule

// File: rtl/sysrst_guard.sv
module sysrst_guard
  import sysrst_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int WD_LIMIT    = 40
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        pll_unlock,
  input  logic        pwr_fail,
  input  logic        ext_rst_n,
  input  logic        std_mode,
  input  logic        wd_kick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sys_rst
);
  logic [NCAUSE-1:0] cause;
  logic              wd_fire;
  logic              wd_en;
  logic              src_any;

  assign cause[CAUSE_PLL]  = pll_unlock;
  assign cause[CAUSE_WDOG] = wd_fire;
  assign cause[CAUSE_PWR]  = pwr_fail;
  assign cause[CAUSE_EXT]  = std_mode && !ext_rst_n;
  assign src_any = |cause;

  sysrst_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
    .clk(clk), .por_n(por_n), .src_any(src_any), .sys_rst(sys_rst));

  sysrst_wdog #(.WD_LIMIT(WD_LIMIT)) u_wdog (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .wd_en(wd_en),
    .kick(wd_kick), .wd_fire(wd_fire));

  sysrst_regs u_regs (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .cause_in(cause),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_en(wd_en));

  // R5: the external pin is ignored outside the standard interface mode
  a_r5_pin_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (!std_mode && !pll_unlock && !pwr_fail && !wd_fire && !sys_rst) |=> !sys_rst);
  // R6: a timeout leads to a system reset
  a_r6_fire_resets: assert property (@(posedge clk) disable iff (!por_n)
    wd_fire |=> sys_rst);
endmodule

// File: tb/sim_sysrst_guard.sv
module sim_sysrst_guard;
  localparam int HOLD = 8;
  localparam int WDL  = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pll_unlock = 1'b0, pwr_fail = 1'b0, ext_rst_n = 1'b1, std_mode = 1'b0;
  logic wd_kick = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic sys_rst;

  int total = 0;
  int fails = 0;
  bit kick_en = 1'b0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sysrst_guard #(.HOLD_CYCLES(HOLD), .WD_LIMIT(WDL)) u0 (
    .clk(clk), .por_n(por_n), .pll_unlock(pll_unlock), .pwr_fail(pwr_fail),
    .ext_rst_n(ext_rst_n), .std_mode(std_mode), .wd_kick(wd_kick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst(sys_rst));

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // Background service strobe
  initial begin
    int kc = 0;
    forever begin
      @(posedge clk); #1;
      wd_kick = kick_en && (kc % 10 == 0);
      kc++;
    end
  end

  // Monitor: pops expected read data from the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (bus_sel && !bus_wr) begin
        if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", bus_rdata, 0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(bus_rdata == e, t, bus_rdata, e);
        end
      end
    end
  end

  task automatic rd(logic a, logic [15:0] e, string t);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wr(logic a, logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pulse_pll();
    @(posedge clk); #1; pll_unlock = 1'b1;
    @(posedge clk); #1; pll_unlock = 1'b0;
  endtask

  // Count negedges with sys_rst high; returns on the first low sample
  task automatic count_high(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (sys_rst && n < 1000) n++;
      else break;
    end
  endtask

  task automatic wait_low();
    int n;
    count_high(n);
  endtask

  initial begin
    int n;
    int m;
    int bad;
    // R1: power-on
    repeat (3) @(negedge clk);
    chk(sys_rst == 1'b1, "R1 reset during por", sys_rst, 1);
    @(posedge clk); #1; por_n = 1'b1; kick_en = 1'b1;
    wait_low();
    rd(1'b1, 16'h3000, "R1 R11 status after por");
    rd(1'b0, 16'h3000, "R1 R11 config after por");

    // R2 R3: PLL loss, exact hold
    pulse_pll();
    count_high(n);
    chk(n == HOLD, "R2 hold length", n, HOLD);
    rd(1'b1, 16'h3100, "R3 pll cause bit 8");
    rd(1'b1, 16'h3000, "R10 cleared after read");

    // R4 R10: power fail then another reset; bits accumulate
    @(posedge clk); #1; pwr_fail = 1'b1;
    @(posedge clk); #1; pwr_fail = 1'b0;
    count_high(n);
    chk(n == HOLD, "R4 reset on power fail", n, HOLD);
    pulse_pll();
    wait_low();
    rd(1'b1, 16'h3500, "R4 R10 bits 10 and 8 sticky");

    // R5: external pin gated by mode
    std_mode = 1'b0;
    @(posedge clk); #1; ext_rst_n = 1'b0;
    bad = 0;
    repeat (5) begin @(negedge clk); if (sys_rst) bad++; end
    @(posedge clk); #1; ext_rst_n = 1'b1;
    @(negedge clk); if (sys_rst) bad++;
    chk(bad == 0, "R5 pin ignored outside mode", bad, 0);
    rd(1'b1, 16'h3000, "R5 no bit 11 outside mode");
    @(posedge clk); #1; std_mode = 1'b1; ext_rst_n = 1'b0;
    @(posedge clk); #1; ext_rst_n = 1'b0;
    @(posedge clk); #1; ext_rst_n = 1'b1;
    count_high(n);
    chk(n == HOLD, "R5 pin reset in mode", n, HOLD);
    rd(1'b1, 16'h3800, "R5 bit 11 in mode");

    // R8 R11: disable watchdog, status write ignored
    wr(1'b0, 16'hFFFF);
    rd(1'b0, 16'h3200, "R8 only bit 9 kept");
    wr(1'b1, 16'hFFFF);
    rd(1'b1, 16'h3000, "R11 status write ignored");
    kick_en = 1'b0;
    bad = 0;
    repeat (3 * WDL) begin @(negedge clk); if (sys_rst) bad++; end
    chk(bad == 0, "R8 disabled watchdog silent", bad, 0);

    // R9: reset re-enables
    kick_en = 1'b1;
    pulse_pll();
    wait_low();
    rd(1'b0, 16'h3000, "R9 config cleared by reset");
    rd(1'b1, 16'h3100, "R9 cause pll");

    // R6: exact timeout
    kick_en = 1'b0;
    pulse_pll();
    count_high(n);
    chk(n == HOLD, "R2 hold before timeout", n, HOLD);
    m = 1;
    forever begin
      @(negedge clk);
      if (!sys_rst && m < 1000) m++;
      else break;
    end
    chk(m == WDL + 1, "R6 timeout cycle", m, WDL + 1);
    kick_en = 1'b1;
    wait_low();
    rd(1'b1, 16'h3300, "R6 bit 9 set");

    // R10: source in the cycle of the read wins
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1; pll_unlock = 1'b1;
    exp_q.push_back(16'h3000); tag_q.push_back("R10 read during source");
    @(posedge clk); #1;
    bus_sel = 1'b0; pll_unlock = 1'b0;
    wait_low();
    rd(1'b1, 16'h3100, "R10 new bit survives clear");

    // R7: regular kicks hold off the watchdog
    bad = 0;
    repeat (6 * WDL) begin @(negedge clk); if (sys_rst) bad++; end
    chk(bad == 0, "R7 kicks prevent reset", bad, 0);
    rd(1'b0, 16'h3000, "R7 R11 config still enabled");

    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule